// File: doc/BRIEF.md
# Iterative 32x32 Multiplier With Signed High-Half Corrections

This block multiplies two 32-bit operands over a fixed number of clock cycles using one shared shift-and-add loop. In each step of that loop, two accumulators advance together. The low word of the product grows by shifting left and then adding the multiplicand. The unsigned high word grows by adding the multiplicand and then shifting right, with the carry of the add entering the top bit.

When the loop ends, one extra cycle turns the unsigned high word into a signed-by-unsigned or signed-by-signed high word by subtracting the other operand where needed. That cycle also registers the word chosen by a 6-bit operation code. An immediate mode replaces the second operand with a sign-extended 16-bit value and always returns the low word.

A request is made by pulsing `start` while the unit is idle. `busy` covers the loop and the correction cycle. `done` then pulses for one cycle, and `result` holds the answer until the next operation completes.

The controller has four states:
- `ST_IDLE` goes to `ST_LOOP` when `start` is high, and stays put otherwise.
- `ST_LOOP` performs one step per cycle and goes to `ST_FIX` after the last of its W steps.
- `ST_FIX` applies the corrections, registers the result and goes to `ST_DONE`.
- `ST_DONE` raises `done` and always returns to `ST_IDLE`.

Top module: `iter_mul_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` sampled while idle makes `busy` 1 from the next cycle. `busy` then stays 1 for exactly W+1 = 33 cycles, which are 32 loop steps and one correction cycle.
- R3: `done` is 1 for exactly one cycle, the first cycle after `busy` falls, and is never 1 while `busy` is 1.
- R4: Operation code 0x27 returns the low 32 bits of the product. These bits are the same whether the operands are read as signed or unsigned.
- R5: Operation code 0x07 returns the high 32 bits of the unsigned-by-unsigned 64-bit product.
- R6: Operation code 0x17 returns the high 32 bits of the product with `mcand` read as signed and `mplier` read as unsigned.
- R7: Operation code 0x1f returns the high 32 bits of the signed-by-signed product.
- R8: With `imm_mode` at 1 when `start` is sampled, the second operand is `imm16` sign-extended to 32 bits and the low-word result is returned. In this mode `op_code` and `mplier` are ignored.
- R9: Any operation code other than 0x27, 0x07 and 0x17 returns the signed-by-signed high word.
- R10: While the unit is busy, `start` and all operand inputs are ignored. The result depends only on the values sampled with the accepted `start`.
- R11: `result` changes only in the cycle in which `done` is 1, and it holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| op_code | input | 6 | Operation select (0x27, 0x07, 0x17, 0x1f) |
| imm_mode | input | 1 | 1: use sign-extended `imm16` as multiplier, low word |
| mcand | input | 32 | First operand (multiplicand) |
| mplier | input | 32 | Second operand (multiplier) |
| imm16 | input | 16 | Immediate multiplier used in immediate mode |
| busy | output | 1 | High during the loop and the correction cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Selected product word, held until the next completion |

## Verification
The bench walks both operands through their sign bits: all-ones times all-ones, the most negative value squared, and a most-negative times a most-positive value. A design that drops the carry into the high accumulator, or applies the two subtract corrections in the wrong order or with the wrong operand, returns a wrong high word on these vectors while still passing small positive ones. An unlisted operation code checks that the fall-through choice is the signed-by-signed word. Immediate mode runs with a negative immediate and a conflicting `op_code` and `mplier`, which shows up a missing sign extension or a leaking operation code. Operands are also changed, and `start` pulsed again, in the middle of a run; a design that reads its inputs after the start cycle produces a different answer.

// File: rtl/imul_pkg.sv
package imul_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_LO   = 6'h27;
    localparam logic [OPC_W-1:0] OPC_UHI  = 6'h07;
    localparam logic [OPC_W-1:0] OPC_SUHI = 6'h17;
    localparam logic [OPC_W-1:0] OPC_SSHI = 6'h1f;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOP,
        ST_FIX,
        ST_DONE
    } imul_state_e;

    typedef enum logic [1:0] {
        PICK_LO,
        PICK_UHI,
        PICK_SUHI,
        PICK_SSHI
    } imul_pick_e;

    // Map an operation code to the word the unit will return.
    // Immediate mode always picks the low word; unknown codes fall to signed-signed.
    function automatic imul_pick_e decode_pick(input logic [OPC_W-1:0] opc,
                                               input logic             imm);
        imul_pick_e p;
        if (imm) begin
            p = PICK_LO;
        end else begin
            case (opc)
                OPC_LO:   p = PICK_LO;
                OPC_UHI:  p = PICK_UHI;
                OPC_SUHI: p = PICK_SUHI;
                default:  p = PICK_SSHI;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/imul_ctrl.sv
module imul_ctrl
    import imul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    imul_state_e state_q, state_d;
    logic [CW-1:0] step_cnt_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOOP;
            ST_LOOP: if (step_cnt_q == LAST_STEP) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // State register and loop counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOOP) begin
                step_cnt_q <= step_cnt_q + 1'b1;
            end else begin
                step_cnt_q <= '0;
            end
        end
    end

    // Outputs from the state register
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        fix  = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_LOOP: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FIX: begin
                fix  = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

endmodule

// File: rtl/imul_core.sv
module imul_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] lo_acc,
    output logic [W-1:0] hi_acc,
    output logic [W-1:0] a_keep,
    output logic [W-1:0] b_keep
);

    logic [W-1:0] msb_walk_q;   // multiplier copy shifted left, consumed from the top
    logic [W-1:0] lsb_walk_q;   // multiplier copy shifted right, consumed from the bottom
    logic [W-1:0] lo_next;
    logic [W:0]   hi_sum;

    // Low word: shift first, then add. High word: add, then shift with carry in.
    always_comb begin
        lo_next = (lo_acc << 1) + (msb_walk_q[W-1] ? a_keep : '0);
        hi_sum  = {1'b0, hi_acc} + {1'b0, (lsb_walk_q[0] ? a_keep : '0)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_acc     <= '0;
            hi_acc     <= '0;
            a_keep     <= '0;
            b_keep     <= '0;
            msb_walk_q <= '0;
            lsb_walk_q <= '0;
        end else if (load) begin
            lo_acc     <= '0;
            hi_acc     <= '0;
            a_keep     <= a_in;
            b_keep     <= b_in;
            msb_walk_q <= b_in;
            lsb_walk_q <= b_in;
        end else if (step) begin
            lo_acc     <= lo_next;
            hi_acc     <= hi_sum[W:1];
            msb_walk_q <= msb_walk_q << 1;
            lsb_walk_q <= lsb_walk_q >> 1;
        end
    end

endmodule

// File: rtl/imul_pick.sv
module imul_pick
    import imul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         fix,
    input  imul_pick_e   pick_in,
    input  logic [W-1:0] lo_acc,
    input  logic [W-1:0] hi_acc,
    input  logic [W-1:0] a_keep,
    input  logic [W-1:0] b_keep,
    output logic [W-1:0] result
);

    imul_pick_e   pick_q;
    logic [W-1:0] su_word;
    logic [W-1:0] ss_word;
    logic [W-1:0] chosen;

    // Signed corrections: remove the partial product of each sign bit.
    always_comb begin
        su_word = hi_acc - (a_keep[W-1] ? b_keep : '0);
        ss_word = su_word - (b_keep[W-1] ? a_keep : '0);
        unique case (pick_q)
            PICK_LO:   chosen = lo_acc;
            PICK_UHI:  chosen = hi_acc;
            PICK_SUHI: chosen = su_word;
            PICK_SSHI: chosen = ss_word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pick_q <= PICK_LO;
            result <= '0;
        end else begin
            if (load) pick_q <= pick_in;
            if (fix)  result <= chosen;
        end
    end

endmodule

// File: rtl/iter_mul_unit.sv
module iter_mul_unit
    import imul_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OPC_W-1:0] op_code,
    input  logic             imm_mode,
    input  logic [W-1:0]     mcand,
    input  logic [W-1:0]     mplier,
    input  logic [IMM_W-1:0] imm16,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     result
);

    localparam int EXT_W = W - IMM_W;

    logic         load;
    logic         step;
    logic         fix;
    logic [W-1:0] b_sel;
    logic [W-1:0] lo_acc;
    logic [W-1:0] hi_acc;
    logic [W-1:0] a_keep;
    logic [W-1:0] b_keep;
    imul_pick_e   pick_in;

    always_comb begin
        b_sel   = imm_mode ? {{EXT_W{imm16[IMM_W-1]}}, imm16} : mplier;
        pick_in = decode_pick(op_code, imm_mode);
    end

    imul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy),
        .done  (done)
    );

    imul_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .a_in   (mcand),
        .b_in   (b_sel),
        .lo_acc (lo_acc),
        .hi_acc (hi_acc),
        .a_keep (a_keep),
        .b_keep (b_keep)
    );

    imul_pick #(.W(W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .fix     (fix),
        .pick_in (pick_in),
        .lo_acc  (lo_acc),
        .hi_acc  (hi_acc),
        .a_keep  (a_keep),
        .b_keep  (b_keep),
        .result  (result)
    );

endmodule

// File: rtl/imul_check.sv
module imul_check #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);

    localparam int RW = $clog2(W + 2) + 1;

    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_len <= '0;
        else if (!busy) run_len <= '0;
        else            run_len <= run_len + 1'b1;
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RW'(W + 1)));

    assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind iter_mul_unit imul_check #(.W(W)) u_imul_check (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/tb_iter_mul_unit.sv
`timescale 1ns/1ps
module tb_iter_mul_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  op_code = 6'h27;
    logic        imm_mode = 1'b0;
    logic [31:0] mcand = '0;
    logic [31:0] mplier = '0;
    logic [15:0] imm16 = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    iter_mul_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .imm_mode(imm_mode), .mcand(mcand), .mplier(mplier), .imm16(imm16),
        .busy(busy), .done(done), .result(result)
    );

    localparam int NV = 11;
    localparam logic [31:0] VA [NV] = '{32'h0000_0007, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h8000_0000, 32'h8000_0000, 32'h1234_5678, 32'h1234_5678, 32'hDEAD_BEEF,
        32'h0000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFE};
    localparam logic [31:0] VB [NV] = '{32'h0000_0006, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h8000_0000, 32'hFFFF_FFFF, 32'h9ABC_DEF0, 32'h9ABC_DEF0, 32'h0000_0003,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0005};
    localparam logic [5:0] VOP [NV] = '{6'h27, 6'h07, 6'h1f, 6'h1f, 6'h17, 6'h27,
        6'h07, 6'h17, 6'h07, 6'h1f, 6'h3f};

    // Reference from the requirements, using 64-bit arithmetic.
    function automatic logic [31:0] ref_word(input logic [31:0] a, input logic [31:0] b,
                                             input logic [5:0] op);
        logic [63:0] p;
        case (op)
            6'h27: begin p = {32'b0, a} * {32'b0, b}; return p[31:0]; end
            6'h07: begin p = {32'b0, a} * {32'b0, b}; return p[63:32]; end
            6'h17: begin p = {{32{a[31]}}, a} * {32'b0, b}; return p[63:32]; end
            default: begin p = {{32{a[31]}}, a} * {{32{b[31]}}, b}; return p[63:32]; end
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op);
        case (op)
            6'h27: return "R4";
            6'h07: return "R5";
            6'h17: return "R6";
            6'h1f: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation; returns result, latency in cycles, and done pulse width check.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [5:0] op,
                          input logic imm, input logic [15:0] iv,
                          output logic [31:0] res, output int lat, output logic one_shot,
                          output logic busy_seen);
        @(negedge clk);
        mcand = a; mplier = b; op_code = op; imm_mode = imm; imm16 = iv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_seen = busy;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        res = result;
        @(negedge clk);
        one_shot = !done && !busy;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] res;
        int          lat;
        logic        one;
        logic        bsy;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R4..R7, R9
        for (int i = 0; i < NV; i++) begin
            run_op(VA[i], VB[i], VOP[i], 1'b0, 16'h0, res, lat, one, bsy);
            check(req_of(VOP[i]), res, ref_word(VA[i], VB[i], VOP[i]));
        end

        // R2 and R3: timing of busy and done
        run_op(32'h0000_0003, 32'h0000_0005, 6'h27, 1'b0, 16'h0, res, lat, one, bsy);
        check("R2 busy after start", {31'b0, bsy}, 32'd1);
        check("R2 latency", lat, 32'd34);
        check("R3 done one cycle", {31'b0, one}, 32'd1);

        // R8: negative immediate, conflicting op_code and mplier
        run_op(32'h0000_0003, 32'hDEAD_BEEF, 6'h07, 1'b1, 16'hFFFE, res, lat, one, bsy);
        check("R8 neg imm", res, 32'hFFFF_FFFA);
        run_op(32'h0001_0001, 32'h1234_5678, 6'h1f, 1'b1, 16'h7FFF, res, lat, one, bsy);
        check("R8 pos imm", res, 32'h7FFF_7FFF);

        // R10: inputs and start changed mid-run are ignored
        @(negedge clk);
        mcand = 32'h8000_0001; mplier = 32'hFFFF_FFF0; op_code = 6'h17; imm_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        mcand = 32'h1111_1111; mplier = 32'h2222_2222; op_code = 6'h27; imm_mode = 1'b1;
        imm16 = 16'h8000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R10 mid-run ignored", result, ref_word(32'h8000_0001, 32'hFFFF_FFF0, 6'h17));
        res = result;

        // R11: result holds after done while idle
        repeat (4) @(negedge clk);
        check("R11 hold", result, res);
        check("R10 no restart", {31'b0, busy}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule